// File: doc/BRIEF.md
# Partitioned SIMD Element Shifter

This block shifts every element of a 128-bit vector in one registered step. A runtime size code splits the vector into lanes of 8, 16, 32 or 64 bits. Each lane is shifted on its own, to the left or to the right, with zero fill or sign fill. Bits never move from one lane into the next.

The shift count comes from one of two places. In per-lane mode, each lane of a second vector supplies its own count. In broadcast mode, one scalar count serves every lane. That scalar is either an immediate displacement or the low bits of an already computed address, picked by a flag that says whether a base register was named. The operation is chosen by an 8-bit secondary opcode.

If the size code or the opcode is invalid, no shift result is produced. The block instead raises a flag and passes the old destination value (`dest_in`) through unchanged. Register reads, address arithmetic and exception handling belong to the surrounding pipeline.

Top module: `simd_element_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `result` = 0, `out_valid` = 0, `spec_err` = 0 and `illegal_op` = 0.
- R2: A left shift moves each lane toward its most significant bit. Zeros enter at the lane's low end, and no bit passes into a neighbouring lane.
- R3: A logical right shift moves each lane toward bit 0. Zeros enter at the lane's high end.
- R4: An arithmetic right shift fills each lane from that lane's own sign bit.
- R5: In per-lane mode, lane i of `result` is lane i of `vec_src` shifted by lane i of `vec_cnt`. Only the low log2(lane width) bits of that count are used. Lane 0 is the most significant lane, bits 127 down to 128 minus the lane width.
- R6: In broadcast mode with `base_nz` = 0, the count is `disp`, masked to its low log2(lane width) bits. For example, 9 acts as 1 for bytes, and 127 acts as 63 for 64-bit lanes.
- R7: In broadcast mode with `base_nz` = 1, the count is `addr`, masked in the same way, and `disp` is ignored.
- R8: The size code on `elem_size` selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. For a legal opcode with a size code above 3, `spec_err` = 1 and `result` = `dest_in`.
- R9: For an opcode outside the six listed in R10, `illegal_op` = 1, `spec_err` = 0 and `result` = `dest_in`.
- R10: The opcodes are as follows. Per-lane mode: 0x70 = left, 0x7A = arithmetic right, 0x78 = logical right. Broadcast mode: 0x30 = left, 0x3A = arithmetic right, 0x38 = logical right.
- R11: The result appears one cycle after `in_valid`. `out_valid` mirrors `in_valid` delayed by one cycle, and neither flag is raised while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_sel | input | 8 | Secondary opcode |
| elem_size | input | 4 | Element size code |
| base_nz | input | 1 | Broadcast count taken from `addr` instead of `disp` |
| disp | input | DISP_W (12) | Immediate displacement count |
| addr | input | ADDR_W (64) | Computed address supplying a count |
| vec_src | input | VEC_W (128) | Vector to shift |
| vec_cnt | input | VEC_W (128) | Per-lane count vector |
| dest_in | input | VEC_W (128) | Old destination value, returned on error |
| result | output | VEC_W (128) | Shifted vector or passed destination |
| out_valid | output | 1 | `result` and the flags are valid |
| spec_err | output | 1 | Invalid size code seen |
| illegal_op | output | 1 | Unrecognised opcode seen |

## Verification
The bench builds the block with its default parameters: a 128-bit vector, a 12-bit displacement and a 64-bit address. All four lane widths therefore exist at once, as 16, 8, 4 and 2 lanes, and one stimulus table reaches every width. Masking is tested with counts and addresses whose discarded bits are set. Lane isolation is tested with patterns whose lane edges carry ones, which would show up as stray bits in a neighbouring lane.

// File: rtl/simd_shift_pkg.sv
// Package: types shared by the element shifter.
// Assumes the opcodes are one byte wide and lane widths are 8 << size code.
package simd_shift_pkg;

    typedef enum logic [1:0] {
        SK_LEFT      = 2'd0,
        SK_RIGHT_LOG = 2'd1,
        SK_RIGHT_ARI = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic        legal;
        logic        per_lane;
        shift_kind_e kind;
    } op_decode_t;

    localparam int NUM_SIZES = 4;
    localparam int MAX_ELEM_W = 8 << (NUM_SIZES - 1);
    localparam int SCNT_W = $clog2(MAX_ELEM_W);

endpackage

// File: rtl/shift_op_decode.sv
// Module: turns the secondary opcode into mode, shift kind and a legal bit.
// Assumes only the six listed opcodes are legal; all others decode as illegal.
module shift_op_decode
    import simd_shift_pkg::*;
(
    input  logic [7:0] op_sel,
    output op_decode_t dec
);

    // Opcode lookup.
    always_comb begin
        dec = '{legal: 1'b1, per_lane: 1'b0, kind: SK_LEFT};
        case (op_sel)
            8'h70: dec = '{legal: 1'b1, per_lane: 1'b1, kind: SK_LEFT};
            8'h7A: dec = '{legal: 1'b1, per_lane: 1'b1, kind: SK_RIGHT_ARI};
            8'h78: dec = '{legal: 1'b1, per_lane: 1'b1, kind: SK_RIGHT_LOG};
            8'h30: dec = '{legal: 1'b1, per_lane: 1'b0, kind: SK_LEFT};
            8'h3A: dec = '{legal: 1'b1, per_lane: 1'b0, kind: SK_RIGHT_ARI};
            8'h38: dec = '{legal: 1'b1, per_lane: 1'b0, kind: SK_RIGHT_LOG};
            default: dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_shifter.sv
// Module: shifts one lane of width W by an already masked count.
// Assumes cnt carries exactly log2(W) bits, so a shift never reaches W.
module lane_shifter
    import simd_shift_pkg::*;
#(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [CW-1:0] cnt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  shifted
);

    // Per-lane shift of the selected kind.
    always_comb begin
        case (kind)
            SK_LEFT:      shifted = data << cnt;
            SK_RIGHT_LOG: shifted = data >> cnt;
            SK_RIGHT_ARI: shifted = W'($signed(data) >>> cnt);
            default:      shifted = data;
        endcase
    end

endmodule

// File: rtl/width_shifter.sv
// Module: splits the vector into lanes of ELEM_W bits and shifts each one.
// Assumes VEC_W is a multiple of ELEM_W. Lane 0 is the most significant lane.
module width_shifter
    import simd_shift_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8,
    localparam int LANES = VEC_W / ELEM_W,
    localparam int CW    = $clog2(ELEM_W)
) (
    input  logic [VEC_W-1:0]  vec_src,
    input  logic [VEC_W-1:0]  vec_cnt,
    input  logic [SCNT_W-1:0] scalar_cnt,
    input  logic              per_lane,
    input  shift_kind_e       kind,
    output logic [VEC_W-1:0]  vec_out
);

    // Count bits above the lane mask are dropped on purpose.
    logic unused_cnt_bits;
    assign unused_cnt_bits = ^{vec_cnt, scalar_cnt};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = VEC_W - 1 - i * ELEM_W;
        logic [CW-1:0] lane_cnt;

        // Pick this lane's count and mask it to the lane width.
        assign lane_cnt = per_lane ? vec_cnt[HI-ELEM_W+1 +: CW] : scalar_cnt[CW-1:0];

        lane_shifter #(.W(ELEM_W)) u_lane (
            .data    (vec_src[HI -: ELEM_W]),
            .cnt     (lane_cnt),
            .kind    (kind),
            .shifted (vec_out[HI -: ELEM_W])
        );
    end

endmodule

// File: rtl/simd_element_shifter.sv
// Module: top of the partitioned element shifter with one register stage.
// Assumes ADDR_W and DISP_W are both at least SCNT_W. Invalid inputs return dest_in.
module simd_element_shifter
    import simd_shift_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int ADDR_W = 64,
    parameter int DISP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        op_sel,
    input  logic [3:0]        elem_size,
    input  logic              base_nz,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_W-1:0]  vec_src,
    input  logic [VEC_W-1:0]  vec_cnt,
    input  logic [VEC_W-1:0]  dest_in,
    output logic [VEC_W-1:0]  result,
    output logic              out_valid,
    output logic              spec_err,
    output logic              illegal_op
);

    op_decode_t        dec;
    logic [SCNT_W-1:0] scalar_cnt;
    logic [VEC_W-1:0]  by_size [NUM_SIZES];
    logic [VEC_W-1:0]  shifted;
    logic              size_bad;

    // High count bits are masked away in every lane.
    logic unused_count_bits;
    assign unused_count_bits = ^{addr[ADDR_W-1:SCNT_W], disp[DISP_W-1:SCNT_W]};

    shift_op_decode u_dec (
        .op_sel (op_sel),
        .dec    (dec)
    );

    // Broadcast count source: address or displacement.
    assign scalar_cnt = base_nz ? addr[SCNT_W-1:0] : disp[SCNT_W-1:0];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        width_shifter #(.VEC_W(VEC_W), .ELEM_W(8 << g)) u_width (
            .vec_src    (vec_src),
            .vec_cnt    (vec_cnt),
            .scalar_cnt (scalar_cnt),
            .per_lane   (dec.per_lane),
            .kind       (dec.kind),
            .vec_out    (by_size[g])
        );
    end

    // Size code check and lane-width selection.
    assign size_bad = |elem_size[3:2];
    assign shifted  = by_size[elem_size[1:0]];

    // Output register: result or passed destination, plus flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            out_valid  <= 1'b0;
            spec_err   <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            spec_err   <= 1'b0;
            illegal_op <= 1'b0;
            if (in_valid) begin
                if (!dec.legal) begin
                    result     <= dest_in;
                    illegal_op <= 1'b1;
                end else if (size_bad) begin
                    result   <= dest_in;
                    spec_err <= 1'b1;
                end else begin
                    result <= shifted;
                end
            end
        end
    end

endmodule

// File: rtl/simd_shift_checker.sv
// Module: assertions on the element shifter's ports, bound to the top.
// Assumes the same port names and default parameters as the top.
module simd_shift_checker #(
    parameter int VEC_W  = 128,
    parameter int ADDR_W = 64,
    parameter int DISP_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        op_sel,
    input logic [3:0]        elem_size,
    input logic              base_nz,
    input logic [DISP_W-1:0] disp,
    input logic [ADDR_W-1:0] addr,
    input logic [VEC_W-1:0]  vec_src,
    input logic [VEC_W-1:0]  vec_cnt,
    input logic [VEC_W-1:0]  dest_in,
    input logic [VEC_W-1:0]  result,
    input logic              out_valid,
    input logic              spec_err,
    input logic              illegal_op
);

    logic op_known;
    assign op_known = (op_sel == 8'h70) || (op_sel == 8'h7A) || (op_sel == 8'h78) ||
                      (op_sel == 8'h30) || (op_sel == 8'h3A) || (op_sel == 8'h38);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !spec_err && !illegal_op && result == '0));

    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_err || illegal_op) |-> out_valid);

    // R8
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_known && elem_size > 4'd3) |=>
        (spec_err && !illegal_op && result == $past(dest_in)));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_known) |=>
        (illegal_op && !spec_err && result == $past(dest_in)));

endmodule

bind simd_element_shifter simd_shift_checker #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)
) u_shift_chk (.*);

// File: tb/test_simd_element_shifter.sv
// Bench: one stimulus table walked in a loop, then directed reset and latency tests.
module test_simd_element_shifter;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [8*8-1:0] tags;
        logic [7:0]     op;
        logic [3:0]     size;
        logic           bnz;
        logic [11:0]    disp;
        logic [63:0]    addr;
        logic [127:0]   src;
        logic [127:0]   cnt;
        logic [127:0]   dest;
        logic [127:0]   exp;
        logic           exp_spec;
        logic           exp_ill;
    } row_t;

    localparam int ROWS = 13;
    localparam logic [127:0] DST = {4{32'hDEADBEEF}};

    localparam row_t TABLE [ROWS] = '{
        // bytes, left by 1: the carry-out must not reach the next lane
        '{"R2 R6 R10", 8'h30, 4'd0, 1'b0, 12'd1, 64'd0, {16{8'h81}}, '0, DST, {16{8'h02}}, 1'b0, 1'b0},
        // displacement 9 masked to 1 for bytes
        '{"R6 R2", 8'h30, 4'd0, 1'b0, 12'd9, 64'd0, {16{8'h81}}, '0, DST, {16{8'h02}}, 1'b0, 1'b0},
        '{"R3 R10", 8'h38, 4'd1, 1'b0, 12'd4, 64'd0, {8{16'h8001}}, '0, DST, {8{16'h0800}}, 1'b0, 1'b0},
        '{"R4 R10", 8'h3A, 4'd2, 1'b0, 12'd4, 64'd0, {4{32'h80000010}}, '0, DST, {4{32'hF8000001}}, 1'b0, 1'b0},
        // 127 masked to 63 for 64-bit lanes
        '{"R4 R6", 8'h3A, 4'd3, 1'b0, 12'd127, 64'd0, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, '0, DST, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 1'b0, 1'b0},
        // address low bits 0xB masked to 3; the displacement is ignored
        '{"R7 R3", 8'h38, 4'd0, 1'b1, 12'd1, 64'hFFFF_FFFF_FFFF_FF0B, {16{8'hF0}}, '0, DST, {16{8'h1E}}, 1'b0, 1'b0},
        '{"R5 R2 R10", 8'h70, 4'd2, 1'b0, 12'd5, 64'd0, {4{32'h1}}, {32'd0, 32'd1, 32'd31, 32'd33}, DST, {32'h1, 32'h2, 32'h80000000, 32'h2}, 1'b0, 1'b0},
        '{"R5 R4 R10", 8'h7A, 4'd0, 1'b0, 12'd0, 64'd0, {16{8'h80}}, {8{8'h07, 8'h0A}}, DST, {8{8'hFF, 8'hE0}}, 1'b0, 1'b0},
        '{"R5 R3 R10", 8'h78, 4'd3, 1'b0, 12'd0, 64'd0, {2{64'hF000_0000_0000_0000}}, {64'd4, 64'd68}, DST, {2{64'h0F00_0000_0000_0000}}, 1'b0, 1'b0},
        '{"R8", 8'h30, 4'd4, 1'b0, 12'd1, 64'd0, {16{8'h81}}, '0, DST, DST, 1'b1, 1'b0},
        '{"R9", 8'h31, 4'd0, 1'b0, 12'd1, 64'd0, {16{8'h81}}, '0, DST, DST, 1'b0, 1'b1},
        '{"R8 R5", 8'h70, 4'd7, 1'b0, 12'd0, 64'd0, {16{8'h81}}, {16{8'h01}}, DST, DST, 1'b1, 1'b0},
        '{"R3 R6", 8'h38, 4'd1, 1'b0, 12'd8, 64'd0, {8{16'hABCD}}, '0, DST, {8{16'h00AB}}, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   op_sel = '0;
    logic [3:0]   elem_size = '0;
    logic         base_nz = 1'b0;
    logic [11:0]  disp = '0;
    logic [63:0]  addr = '0;
    logic [127:0] vec_src = '0;
    logic [127:0] vec_cnt = '0;
    logic [127:0] dest_in = '0;
    logic [127:0] result;
    logic         out_valid;
    logic         spec_err;
    logic         illegal_op;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    simd_element_shifter i_simd_element_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .elem_size  (elem_size),
        .base_nz    (base_nz),
        .disp       (disp),
        .addr       (addr),
        .vec_src    (vec_src),
        .vec_cnt    (vec_cnt),
        .dest_in    (dest_in),
        .result     (result),
        .out_valid  (out_valid),
        .spec_err   (spec_err),
        .illegal_op (illegal_op)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 result", result, '0);
        check("R1 flags", {125'd0, out_valid, spec_err, illegal_op}, '0);
        rst_n = 1'b1;

        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            op_sel    = TABLE[r].op;
            elem_size = TABLE[r].size;
            base_nz   = TABLE[r].bnz;
            disp      = TABLE[r].disp;
            addr      = TABLE[r].addr;
            vec_src   = TABLE[r].src;
            vec_cnt   = TABLE[r].cnt;
            dest_in   = TABLE[r].dest;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("%s row %0d result", TABLE[r].tags, r), result, TABLE[r].exp);
            check($sformatf("%s row %0d flags", TABLE[r].tags, r),
                  {125'd0, out_valid, spec_err, illegal_op},
                  {125'd0, 1'b1, TABLE[r].exp_spec, TABLE[r].exp_ill});
        end

        // R11: idle cycle drops out_valid and the flags
        @(negedge clk);
        check("R11 idle", {126'd0, out_valid, spec_err | illegal_op}, '0);

        // R11: a bad opcode leaves its flag for exactly one cycle
        op_sel   = 8'hFF;
        dest_in  = {8{16'h1234}};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 pass-through", result, {8{16'h1234}});
        @(negedge clk);
        check("R11 flag drops", {126'd0, out_valid, illegal_op}, '0);

        // R1: reset in mid-run clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule